// File: doc/BRIEF.md
# Link Integrity and Polarity Monitor

This block keeps the link-integrity state of one 10BASE-T port and repairs a receive pair wired backwards. On the transmit side it emits a short normal link pulse at a fixed interval whenever no frame is being sent. That interval is counted from the end of the last transmission or from the previous pulse.

On the receive side it takes strobes for incoming link pulses and for frame endings, each with a raw polarity bit. A pulse is accepted only if its spacing from the previous pulse lies inside a minimum/maximum window. A loss timer declares the link failed when no accepted pulse or frame arrives for long enough. While the link is failed, the transmit pulse generator is held quiet.

A polarity detector declares the pair reversed once it has seen a reversed link pulse and a run of consecutive frame endings with negative polarity. From then on it inverts the received bit stream. Received bits are dropped while a reversal is suspected but not yet confirmed.

All intervals are counted in ticks of an external timebase strobe, so the same logic serves real-time and shortened settings.

Top module: `link_pol_mon`

## Requirements
- R1: After reset, nlp_out, link_good and pair_rev are 0.
- R2: With tx_active low and link_good high, nlp_out rises in the cycle after the NLP_PERIOD-th tick counted from the last cycle with tx_active high, or from the previous pulse start. It then stays high for exactly NLP_WIDTH clock cycles.
- R3: While tx_active is high, nlp_out is 0 from the next cycle, and the pulse interval restarts.
- R4: No pulse starts while link_good is 0, although the interval timer keeps running.
- R5: A received pulse is qualified when the number of ticks since the previous received pulse is at least SEP_MIN and at most SEP_MAX. The first pulse after reset never qualifies. A qualified pulse sets link_good in the next cycle.
- R6: A pulse closer than SEP_MIN to the previous one is rejected. It neither sets link_good nor restarts the loss timer, but it does become the reference for the next spacing.
- R7: An end-of-frame strobe of either polarity sets link_good and restarts the loss timer.
- R8: link_good falls after LOSS_TICKS ticks with no qualified pulse or frame end.
- R9: pair_rev rises once a reversed link pulse (rx_pulse_neg=1) has been seen and REV_FRAMES consecutive frame endings with eof_neg=1 have occurred, in either order. It then stays set until reset.
- R10: A frame ending with eof_neg=0 clears the consecutive-reversed-frame count, unless the pair is already declared reversed.
- R11: rx_vld_out and rx_bit_out follow rx_bit_vld and rx_bit one cycle later, with the bit inverted when pair_rev is 1. rx_vld_out is 0 while a reversed pulse has been seen and pair_rev is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| tx_active | input | 1 | A frame is being transmitted |
| rx_pulse | input | 1 | Received link pulse strobe |
| rx_pulse_neg | input | 1 | Received pulse had negative (reversed) polarity |
| eof_stb | input | 1 | Received frame ended |
| eof_neg | input | 1 | Frame ending had negative polarity |
| rx_bit | input | 1 | Decoded receive bit |
| rx_bit_vld | input | 1 | rx_bit is valid |
| nlp_out | output | 1 | Transmit link pulse request |
| link_good | output | 1 | Link integrity state |
| pair_rev | output | 1 | Receive pair declared reversed |
| rx_bit_out | output | 1 | Polarity-corrected receive bit |
| rx_vld_out | output | 1 | Corrected bit is valid |

## Verification
The bench builds the block with NLP_PERIOD=20, NLP_WIDTH=3, SEP_MIN=5, SEP_MAX=30, LOSS_TICKS=40 and REV_FRAMES=4, and drives a tick every four clocks. These values bring the pulse interval, both edges of the spacing window and the loss timeout within a few hundred cycles, so a single run can cross each limit on both sides. The short frame run makes it cheap to break a reversed run with a normal ending and to reach the declaration from both orders of evidence.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef struct packed {
    logic stb;
    logic neg;
  } pol_evt_t;
endpackage

// File: rtl/nlp_gen.sv
module nlp_gen #(
  parameter int PERIOD = 16000,
  parameter int WIDTH  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_active,
  input  logic link_en,
  output logic nlp_out
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam int PW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
  localparam logic [PW-1:0] HOLD0 = PW'(WIDTH - 1);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic          fire;

  assign fire = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pcnt    <= '0;
      nlp_out <= 1'b0;
    end else if (tx_active) begin
      cnt     <= '0;
      pcnt    <= '0;
      nlp_out <= 1'b0;
    end else begin
      if (tick) cnt <= fire ? '0 : cnt + 1'b1;
      if (fire && link_en) begin
        nlp_out <= 1'b1;
        pcnt    <= HOLD0;
      end else if (pcnt != '0) begin
        pcnt <= pcnt - 1'b1;
      end else begin
        nlp_out <= 1'b0;
      end
    end
  end

  a_r3_quiet_in_tx: assert property (@(posedge clk) disable iff (rst)
    tx_active |=> !nlp_out);
  a_r4_no_start_when_down: assert property (@(posedge clk) disable iff (rst)
    (!link_en && !nlp_out) |=> !nlp_out);
endmodule

// File: rtl/link_mon.sv
module link_mon #(
  parameter int SEP_MIN = 4000,
  parameter int SEP_MAX = 50000,
  parameter int LOSS    = 80000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_pulse,
  input  logic eof_stb,
  output logic link_good
);
  localparam int GW = $clog2(SEP_MAX + 2);
  localparam int LW = $clog2(LOSS + 1);
  localparam logic [GW-1:0] GMIN = GW'(SEP_MIN);
  localparam logic [GW-1:0] GMAX = GW'(SEP_MAX);
  localparam logic [GW-1:0] GSAT = GW'(SEP_MAX + 1);
  localparam logic [LW-1:0] LLAST = LW'(LOSS - 1);

  logic [GW-1:0] gap;
  logic [LW-1:0] loss_cnt;
  logic          qual, evt;

  assign qual = rx_pulse && (gap >= GMIN) && (gap <= GMAX);
  assign evt  = qual || eof_stb;

  // spacing since the previous received pulse, saturating past the window
  always_ff @(posedge clk) begin
    if (rst)                         gap <= GSAT;
    else if (rx_pulse)               gap <= '0;
    else if (tick && gap != GSAT)    gap <= gap + 1'b1;
  end

  // loss timer and link state
  always_ff @(posedge clk) begin
    if (rst) begin
      loss_cnt  <= '0;
      link_good <= 1'b0;
    end else if (evt) begin
      loss_cnt  <= '0;
      link_good <= 1'b1;
    end else if (tick) begin
      if (loss_cnt == LLAST) link_good <= 1'b0;
      else                   loss_cnt  <= loss_cnt + 1'b1;
    end
  end

  a_r5_qual_sets_good: assert property (@(posedge clk) disable iff (rst)
    qual |=> link_good);
  a_r6_short_rejected: assert property (@(posedge clk) disable iff (rst)
    (rx_pulse && gap < GMIN && !eof_stb && !link_good) |=> !link_good);
  a_r7_eof_sets_good: assert property (@(posedge clk) disable iff (rst)
    eof_stb |=> link_good);
  a_r8_loss_drop: assert property (@(posedge clk) disable iff (rst)
    (!evt && tick && loss_cnt == LLAST) |=> !link_good);
endmodule

// File: rtl/pol_det.sv
module pol_det
  import lpm_pkg::*;
#(
  parameter int REV_FRAMES = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  pol_evt_t pulse,
  input  pol_evt_t eof,
  input  logic     rx_bit,
  input  logic     rx_bit_vld,
  output logic     pair_rev,
  output logic     rx_bit_out,
  output logic     rx_vld_out
);
  localparam int RW = $clog2(REV_FRAMES + 1);
  localparam logic [RW-1:0] RMAX = RW'(REV_FRAMES);

  logic          seen, seen_n, pair_n;
  logic [RW-1:0] run, run_n;

  always_comb begin
    seen_n = seen | (pulse.stb & pulse.neg);
    run_n  = run;
    if (eof.stb) begin
      if (!eof.neg)         run_n = '0;
      else if (run != RMAX) run_n = run + 1'b1;
    end
    pair_n = pair_rev | (seen_n && run_n == RMAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen       <= 1'b0;
      run        <= '0;
      pair_rev   <= 1'b0;
      rx_bit_out <= 1'b0;
      rx_vld_out <= 1'b0;
    end else begin
      seen       <= seen_n;
      run        <= run_n;
      pair_rev   <= pair_n;
      rx_bit_out <= rx_bit ^ pair_rev;
      rx_vld_out <= rx_bit_vld && !(seen && !pair_rev);
    end
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    pair_rev |=> pair_rev);
  a_r9_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    pair_rev |-> seen);
  a_r10_normal_clears: assert property (@(posedge clk) disable iff (rst)
    (eof.stb && !eof.neg && !pair_rev) |=> !pair_rev);
  a_r11_discard: assert property (@(posedge clk) disable iff (rst)
    (seen && !pair_rev) |=> !rx_vld_out);
endmodule

// File: rtl/link_pol_mon.sv
module link_pol_mon
  import lpm_pkg::*;
#(
  parameter int NLP_PERIOD = 16000,
  parameter int NLP_WIDTH  = 2,
  parameter int SEP_MIN    = 4000,
  parameter int SEP_MAX    = 50000,
  parameter int LOSS_TICKS = 80000,
  parameter int REV_FRAMES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_active,
  input  logic rx_pulse,
  input  logic rx_pulse_neg,
  input  logic eof_stb,
  input  logic eof_neg,
  input  logic rx_bit,
  input  logic rx_bit_vld,
  output logic nlp_out,
  output logic link_good,
  output logic pair_rev,
  output logic rx_bit_out,
  output logic rx_vld_out
);
  pol_evt_t pulse_evt, eof_evt;
  assign pulse_evt = '{stb: rx_pulse, neg: rx_pulse_neg};
  assign eof_evt   = '{stb: eof_stb,  neg: eof_neg};

  nlp_gen #(.PERIOD(NLP_PERIOD), .WIDTH(NLP_WIDTH)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .tx_active(tx_active),
    .link_en(link_good), .nlp_out(nlp_out)
  );

  link_mon #(.SEP_MIN(SEP_MIN), .SEP_MAX(SEP_MAX), .LOSS(LOSS_TICKS)) u_link (
    .clk(clk), .rst(rst), .tick(tick), .rx_pulse(rx_pulse),
    .eof_stb(eof_stb), .link_good(link_good)
  );

  pol_det #(.REV_FRAMES(REV_FRAMES)) u_pol (
    .clk(clk), .rst(rst), .pulse(pulse_evt), .eof(eof_evt),
    .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .pair_rev(pair_rev),
    .rx_bit_out(rx_bit_out), .rx_vld_out(rx_vld_out)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!nlp_out && !link_good && !pair_rev));
endmodule

// File: tb/tb_link_pol_mon.sv
module tb_link_pol_mon;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 20, PW = 3, SMIN = 5, SMAX = 30, LOSS = 40, NREV = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_active = 0, rx_pulse = 0, rx_pulse_neg = 0, eof_stb = 0, eof_neg = 0;
  logic rx_bit = 0, rx_bit_vld = 0;
  logic nlp_out, link_good, pair_rev, rx_bit_out, rx_vld_out;
  logic [1:0] ph = 2'd0;
  logic tick;
  int tests = 0, fails = 0, rises = 0;
  bit done = 0;
  logic prev_nlp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ph <= ph + 2'd1;
  assign tick = (ph == 2'd1);

  link_pol_mon #(.NLP_PERIOD(PER), .NLP_WIDTH(PW), .SEP_MIN(SMIN), .SEP_MAX(SMAX),
    .LOSS_TICKS(LOSS), .REV_FRAMES(NREV)) dut (
    .clk(clk), .rst(rst), .tick(tick), .tx_active(tx_active), .rx_pulse(rx_pulse),
    .rx_pulse_neg(rx_pulse_neg), .eof_stb(eof_stb), .eof_neg(eof_neg),
    .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .nlp_out(nlp_out),
    .link_good(link_good), .pair_rev(pair_rev), .rx_bit_out(rx_bit_out),
    .rx_vld_out(rx_vld_out));

  // behavioural reference model, time kept as absolute tick numbers
  int  m_since, m_rem, m_tn, m_lastp, m_le, m_run;
  bit  m_lg, m_seen, m_pair, m_vld, m_bit, m_fire, m_qual;
  always @(posedge clk) begin
    if (rst) begin
      m_since = 0; m_rem = 0; m_tn = 0; m_lastp = -1000000; m_le = 0; m_run = 0;
      m_lg = 0; m_seen = 0; m_pair = 0; m_vld = 0; m_bit = 0;
    end else begin
      if (tx_active) begin m_since = 0; m_rem = 0; end
      else begin
        m_fire = 0;
        if (tick) begin m_since++; if (m_since == PER) begin m_fire = 1; m_since = 0; end end
        if (m_fire && m_lg) m_rem = PW; else if (m_rem > 0) m_rem--;
      end
      m_vld = rx_bit_vld && !(m_seen && !m_pair);
      m_bit = rx_bit ^ m_pair;
      m_qual = rx_pulse && (m_tn - m_lastp >= SMIN) && (m_tn - m_lastp <= SMAX);
      if (rx_pulse) m_lastp = m_tn;
      if (tick && !rx_pulse) m_tn++;
      if (m_qual || eof_stb) begin m_lg = 1; m_le = m_tn; end
      else if (tick && (m_tn - m_le) >= LOSS) m_lg = 0;
      if (rx_pulse && rx_pulse_neg) m_seen = 1;
      if (eof_stb) begin
        if (!eof_neg) m_run = 0; else if (m_run < NREV) m_run++;
      end
      if (m_seen && m_run >= NREV) m_pair = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(nlp_out == (m_rem > 0), "R2 model nlp_out", nlp_out, m_rem > 0);
      chk(link_good == m_lg, "R5 model link_good", link_good, m_lg);
      chk(pair_rev == m_pair, "R9 model pair_rev", pair_rev, m_pair);
      chk(rx_vld_out == m_vld, "R11 model rx_vld_out", rx_vld_out, m_vld);
      if (m_vld) chk(rx_bit_out == m_bit, "R11 model rx_bit_out", rx_bit_out, m_bit);
      if (nlp_out && !prev_nlp) rises++;
      prev_nlp = nlp_out;
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic send_pulse(input bit neg);
    @(negedge clk);
    while (tick) @(negedge clk);
    rx_pulse = 1; rx_pulse_neg = neg;
    @(negedge clk);
    rx_pulse = 0; rx_pulse_neg = 0;
  endtask

  task automatic send_eof(input bit neg);
    @(negedge clk);
    while (tick) @(negedge clk);
    eof_stb = 1; eof_neg = neg;
    @(negedge clk);
    eof_stb = 0; eof_neg = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    prev_nlp = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int r, w;
    do_reset();
    chk(!nlp_out && !link_good && !pair_rev, "R1 reset state", {nlp_out, link_good, pair_rev}, 0);

    rx_bit = 1; rx_bit_vld = 1;
    @(negedge clk);
    chk(rx_vld_out && rx_bit_out, "R11 pass-through bit", {rx_vld_out, rx_bit_out}, 3);
    rx_bit = 0; rx_bit_vld = 0;

    send_pulse(0);
    chk(!link_good, "R5 first pulse not qualified", link_good, 0);
    wait_ticks(10); send_pulse(0);
    chk(link_good, "R5 spaced pulse sets link", link_good, 1);

    wait_ticks(2); send_pulse(0);
    wait_ticks(36);
    chk(link_good, "R8 link kept before loss interval", link_good, 1);
    wait_ticks(3);
    chk(!link_good, "R6 short pulse did not restart loss, R8 link lost", link_good, 0);

    r = rises;
    wait_ticks(2 * PER + 2);
    chk(rises == r, "R4 no pulse while link failed", rises - r, 0);

    send_eof(0);
    chk(link_good, "R7 frame end sets link", link_good, 1);

    tx_active = 1;
    repeat (3) @(negedge clk);
    chk(!nlp_out, "R3 quiet during transmit", nlp_out, 0);
    tx_active = 0;
    r = rises;
    wait_ticks(PER - 1);
    chk(!nlp_out && rises == r, "R2 no pulse before interval", rises - r, 0);
    wait_ticks(1);
    chk(nlp_out, "R2 pulse after interval", nlp_out, 1);
    w = 0;
    while (nlp_out && w < 100) begin w++; @(negedge clk); end
    chk(w == PW, "R2 pulse width", w, PW);

    send_pulse(1);
    rx_bit = 1; rx_bit_vld = 1;
    @(negedge clk);
    chk(!rx_vld_out, "R11 data dropped while reversal suspected", rx_vld_out, 0);
    rx_bit_vld = 0;
    for (int i = 0; i < NREV - 1; i++) send_eof(1);
    send_eof(0);
    for (int i = 0; i < NREV - 1; i++) send_eof(1);
    chk(!pair_rev, "R10 normal frame end broke the run", pair_rev, 0);
    send_eof(1);
    chk(pair_rev, "R9 reversal declared", pair_rev, 1);
    rx_bit = 1; rx_bit_vld = 1;
    @(negedge clk);
    chk(rx_vld_out && !rx_bit_out, "R11 corrected bit inverted", {rx_vld_out, rx_bit_out}, 2);
    rx_bit_vld = 0; rx_bit = 0;
    send_eof(0);
    chk(pair_rev, "R9 reversal sticky", pair_rev, 1);

    do_reset();
    send_pulse(0);
    wait_ticks(SMAX + 5); send_pulse(0);
    chk(!link_good, "R5 pulse beyond max spacing rejected", link_good, 0);
    wait_ticks(SMAX - 2); send_pulse(0);
    chk(link_good, "R5 pulse at upper window accepted", link_good, 1);

    for (int i = 0; i < NREV; i++) send_eof(1);
    chk(!pair_rev, "R9 frames alone do not declare", pair_rev, 0);
    send_pulse(1);
    chk(pair_rev, "R9 reversed pulse after frame run declares", pair_rev, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule